// File: doc/BRIEF.md
# Forwarding Write Queue Between Cache and Memory

This block is a short queue between a cache and main memory. The cache hands it whole-block writes, one per cycle, and goes on working. The queue passes those blocks to memory one at a time, oldest first, through a request and acknowledge handshake. The cache in front can be write-through or write-back.

A block that sits in the queue is newer than the copy in memory. For that reason, a cache read miss must also present its block address on the lookup port. Every held entry is compared with that address in parallel, which takes one comparator per slot. On a match, the queue returns the held data. If more than one entry holds the same block, it returns the one written most recently, so the reader never gets a stale copy. The depth is a parameter that must be a power of two. Because of the comparator count it is meant to stay small, around four to eight blocks.

Top module: `wrq_forward_buf`

## Requirements
- R1: After reset the queue is empty: `wr_ready` is 1, `mem_req` is 0 and `lk_hit` is 0.
- R2: `wr_ready` is 0 exactly when DEPTH entries are held. A write offered while `wr_ready` is 0 is dropped and never reaches memory.
- R3: `mem_req` is 1 whenever at least one entry is held. `mem_addr` and `mem_data` show the oldest held entry, so blocks leave in the order they were accepted.
- R4: An entry leaves the queue only in a cycle with both `mem_req` and `mem_ack` high. While `mem_req` is high and `mem_ack` is low, `mem_addr` and `mem_data` stay unchanged into the next cycle.
- R5: In the same cycle that `lk_valid` is 1, `lk_hit` is 1 if any held entry has an address equal to `lk_addr`. `lk_data` then carries that entry's data.
- R6: When several held entries match the lookup address, `lk_data` carries the one accepted most recently.
- R7: The lookup still sees an entry in the cycle its `mem_ack` arrives. A write accepted in a cycle is visible to lookups from the next cycle on.
- R8: `lk_hit` is 0 while `lk_valid` is 0, and `lk_data` is all zeros whenever `lk_hit` is 0.
- R9: When the queue is not full, one write and one acknowledged drain may happen in the same cycle. Both take effect and the occupancy is unchanged.
- R10: `mem_ack` while `mem_req` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Cache offers a block write |
| wr_ready | output | 1 | Queue can take a write this cycle |
| wr_addr | input | ADDR_W | Block address of the offered write |
| wr_data | input | DATA_W | Block data of the offered write |
| lk_valid | input | 1 | Read-miss lookup is active |
| lk_addr | input | ADDR_W | Block address being looked up |
| lk_hit | output | 1 | A held entry matches the lookup |
| lk_data | output | DATA_W | Newest matching data, zero on no hit |
| mem_req | output | 1 | Oldest entry is offered to memory |
| mem_addr | output | ADDR_W | Block address of the oldest entry |
| mem_data | output | DATA_W | Block data of the oldest entry |
| mem_ack | input | 1 | Memory has taken the offered entry |

## Verification
The bench builds the queue with a 3-bit block address, 8-bit data and a depth of four. With these values every lookup address can be swept in every cycle, and an address pattern repeats several times within the queue. The small depth means the queue fills, wraps its pointers and holds duplicate blocks after only a few writes. That brings the full/drop case, the choice of the newest duplicate, and simultaneous write-and-drain at every occupancy and pointer phase within reach of long arithmetic stimulus runs.

// File: rtl/wrq_pkg.sv
package wrq_pkg;

   function automatic bit wrq_is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

   function automatic int wrq_ptr_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/wrq_ptr_ctrl.sv
module wrq_ptr_ctrl #(
   parameter int DEPTH = 4,
   localparam int PTR_W = wrq_pkg::wrq_ptr_bits(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic             full,
   output logic             empty,
   output logic [DEPTH-1:0] slot_live
);
   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count_q <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign full  = (count_q == CNT_W'(DEPTH));
   assign empty = (count_q == '0);

   // a slot is live when its distance from the head is below the occupancy
   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_live
         logic [PTR_W-1:0] age;
         assign age          = PTR_W'(i) - rd_ptr;
         assign slot_live[i] = ({1'b0, age} < count_q);
      end
   endgenerate
endmodule

// File: rtl/wrq_slot_array.sv
module wrq_slot_array #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int DEPTH  = 4,
   localparam int PTR_W = wrq_pkg::wrq_ptr_bits(DEPTH)
) (
   input  logic                          clk,
   input  logic                          we,
   input  logic [PTR_W-1:0]              wr_idx,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic [PTR_W-1:0]              head_idx,
   output logic [ADDR_W-1:0]             head_addr,
   output logic [DATA_W-1:0]             head_data,
   input  logic [DEPTH-1:0]              slot_live,
   input  logic                          lk_valid,
   input  logic [ADDR_W-1:0]             lk_addr,
   output logic [DEPTH-1:0]              slot_match,
   output logic [DEPTH-1:0][DATA_W-1:0]  slot_data
);
   logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
   logic [DEPTH-1:0][DATA_W-1:0] data_q;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (we && (wr_idx == PTR_W'(i))) begin
               addr_q[i] <= wr_addr;
               data_q[i] <= wr_data;
            end
         end
         // one comparator per slot, all evaluated in parallel
         assign slot_match[i] = lk_valid && slot_live[i] && (addr_q[i] == lk_addr);
         assign slot_data[i]  = data_q[i];
      end
   endgenerate

   assign head_addr = addr_q[head_idx];
   assign head_data = data_q[head_idx];
endmodule

// File: rtl/wrq_newest_sel.sv
module wrq_newest_sel #(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 4,
   localparam int PTR_W = wrq_pkg::wrq_ptr_bits(DEPTH)
) (
   input  logic [PTR_W-1:0]              rd_ptr,
   input  logic [DEPTH-1:0]              slot_match,
   input  logic [DEPTH-1:0][DATA_W-1:0]  slot_data,
   output logic                          hit,
   output logic [DATA_W-1:0]             data
);
   // walk from the oldest slot to the newest; a later match overrides
   always_comb begin
      logic [PTR_W-1:0] idx;
      hit  = 1'b0;
      data = '0;
      idx  = '0;
      for (int k = 0; k < DEPTH; k++) begin
         idx = rd_ptr + PTR_W'(k);
         if (slot_match[idx]) begin
            hit  = 1'b1;
            data = slot_data[idx];
         end
      end
   end
endmodule

// File: rtl/wrq_forward_buf.sv
module wrq_forward_buf #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   input  logic              mem_ack
);
   localparam int PTR_W = wrq_pkg::wrq_ptr_bits(DEPTH);

   generate
      if (!wrq_pkg::wrq_is_pow2(DEPTH)) begin : g_bad_depth
         $error("wrq_forward_buf: DEPTH must be a power of two, at least 2");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("wrq_forward_buf: ADDR_W and DATA_W must be positive");
      end
   endgenerate

   logic [PTR_W-1:0]             wr_ptr, rd_ptr;
   logic                         full, empty, push, pop;
   logic [DEPTH-1:0]             slot_live, slot_match;
   logic [DEPTH-1:0][DATA_W-1:0] slot_data;

   assign wr_ready = !full;
   assign mem_req  = !empty;
   assign push     = wr_valid && !full;
   assign pop      = mem_ack && !empty;

   wrq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .pop       (pop),
      .wr_ptr    (wr_ptr),
      .rd_ptr    (rd_ptr),
      .full      (full),
      .empty     (empty),
      .slot_live (slot_live)
   );

   wrq_slot_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_slots (
      .clk        (clk),
      .we         (push),
      .wr_idx     (wr_ptr),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .head_idx   (rd_ptr),
      .head_addr  (mem_addr),
      .head_data  (mem_data),
      .slot_live  (slot_live),
      .lk_valid   (lk_valid),
      .lk_addr    (lk_addr),
      .slot_match (slot_match),
      .slot_data  (slot_data)
   );

   wrq_newest_sel #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_sel (
      .rd_ptr     (rd_ptr),
      .slot_match (slot_match),
      .slot_data  (slot_data),
      .hit        (lk_hit),
      .data       (lk_data)
   );
endmodule

// File: rtl/wrq_forward_buf_chk.sv
module wrq_forward_buf_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64,
   parameter int DEPTH  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic              lk_valid,
   input logic              lk_hit,
   input logic [DATA_W-1:0] lk_data,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_data,
   input logic              mem_ack
);
   localparam int CNT_W = $clog2(DEPTH + 1) + 1;
   logic [CNT_W-1:0] occ_q;
   logic             seen_clk;

   // occupancy rebuilt from the handshakes alone
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q    <= '0;
         seen_clk <= 1'b0;
      end else begin
         seen_clk <= 1'b1;
         occ_q <= occ_q + CNT_W'(wr_valid && wr_ready) - CNT_W'(mem_req && mem_ack);
      end
   end

   AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_clk |-> (wr_ready && !mem_req && !lk_hit));                       // R1
   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready == (occ_q != CNT_W'(DEPTH)));                                    // R2
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= CNT_W'(DEPTH));                                                  // R2
   AST_REQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req == (occ_q != '0));                                                // R3
   AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data))); // R4
   AST_EMPTY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_q == '0) |-> !lk_hit);                                               // R5
   AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !lk_hit);                                                   // R8
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_data == '0));                                             // R8
   AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && mem_req && mem_ack) |=> (mem_req && wr_ready));  // R9
   AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_req && mem_ack && !wr_valid) |=> !mem_req);                         // R10
endmodule

bind wrq_forward_buf wrq_forward_buf_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_valid (wr_valid),
   .wr_ready (wr_ready),
   .lk_valid (lk_valid),
   .lk_hit   (lk_hit),
   .lk_data  (lk_data),
   .mem_req  (mem_req),
   .mem_addr (mem_addr),
   .mem_data (mem_data),
   .mem_ack  (mem_ack)
);

// File: tb/wrq_forward_buf_tb.sv
`timescale 1ns/1ps
module wrq_forward_buf_tb;
   localparam int AW = 3;
   localparam int DW = 8;
   localparam int DP = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_valid, wr_ready, lk_valid, lk_hit, mem_req, mem_ack;
   logic [AW-1:0] wr_addr, lk_addr, mem_addr;
   logic [DW-1:0] wr_data, lk_data, mem_data;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   // reference queue, index 0 is the oldest entry
   logic [AW-1:0] ma [DP];
   logic [DW-1:0] md [DP];
   int            mc = 0;
   bit            prev_stall = 0, prev_both = 0, prev_stray = 0;

   always #10 clk = ~clk;

   wrq_forward_buf #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack)
   );

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input bit wv, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                      input bit ack, input bit lv, input logic [AW-1:0] la);
      bit            e_ready, e_req, e_hit;
      logic [DW-1:0] e_data;
      int            nmatch;
      string         t;
      @(negedge clk);
      wr_valid = wv; wr_addr = wa; wr_data = wd;
      mem_ack = ack; lk_valid = lv; lk_addr = la;
      #2;
      e_ready = (mc < DP);
      e_req   = (mc > 0);
      chk(wr_ready == e_ready, prev_both ? "R9" : "R2", "wr_ready", wr_ready, e_ready);
      chk(mem_req == e_req, prev_stray ? "R10" : "R3", "mem_req", mem_req, e_req);
      if (e_req) begin
         t = prev_stall ? "R4" : "R3";
         chk(mem_addr == ma[0], t, "mem_addr", mem_addr, ma[0]);
         chk(mem_data == md[0], t, "mem_data", mem_data, md[0]);
      end
      e_hit = 0; e_data = '0; nmatch = 0;
      if (lv) begin
         for (int j = 0; j < mc; j++) begin
            if (ma[j] == la) begin
               e_hit = 1; e_data = md[j]; nmatch++;
            end
         end
      end
      if (!lv)                 t = "R8";
      else if (nmatch > 1)     t = "R6";
      else if (ack && e_req)   t = "R7";
      else                     t = "R5";
      chk(lk_hit == e_hit, t, "lk_hit", lk_hit, e_hit);
      chk(lk_data == e_data, t, "lk_data", lk_data, e_data);
      @(posedge clk);
      prev_stall = e_req && !ack;
      prev_both  = e_req && ack && wv && e_ready;
      prev_stray = !e_req && ack && !wv;
      if (ack && e_req) begin
         for (int j = 0; j < DP - 1; j++) begin
            ma[j] = ma[j+1]; md[j] = md[j+1];
         end
         mc--;
      end
      if (wv && e_ready) begin
         ma[mc] = wa; md[mc] = wd; mc++;
      end
   endtask

   initial begin
      rst_n = 0; wr_valid = 0; wr_addr = '0; wr_data = '0;
      mem_ack = 0; lk_valid = 0; lk_addr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1; lk_valid = 1;
      #2;
      chk(wr_ready == 1'b1, "R1", "wr_ready after reset", wr_ready, 1);
      chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
      chk(lk_hit == 1'b0, "R1", "lk_hit after reset", lk_hit, 0);

      // stray acknowledges on an empty queue (R10)
      for (int k = 0; k < 3; k++) cyc(0, '0, '0, 1, 1, AW'(k));

      // fill with a duplicated block while sweeping lookups (R5, R6, R7)
      cyc(1, 3'd1, 8'h11, 0, 1, 3'd1);
      cyc(1, 3'd2, 8'h22, 0, 1, 3'd1);
      cyc(1, 3'd1, 8'h33, 0, 1, 3'd2);
      cyc(1, 3'd5, 8'h44, 0, 1, 3'd1);
      for (int a = 0; a < 8; a++) cyc(0, '0, '0, 0, 1, AW'(a));
      // offers while full are dropped (R2)
      cyc(1, 3'd7, 8'hEE, 0, 1, 3'd7);
      cyc(1, 3'd7, 8'hEF, 0, 1, 3'd7);
      // slow drain with stalls and lookup on the entry being acked (R4, R7)
      for (int k = 0; k < 10; k++) cyc(0, '0, '0, k[0], 1, (k < 5) ? 3'd1 : 3'd5);
      cyc(0, '0, '0, 0, 0, 3'd1);

      // write and drain together at a held occupancy (R9)
      cyc(1, 3'd6, 8'h61, 0, 1, 3'd6);
      cyc(1, 3'd6, 8'h62, 0, 1, 3'd6);
      for (int k = 0; k < 40; k++)
         cyc(1, AW'(k % 3 + 4), DW'(k * 13 + 7), 1, 1, AW'(k % 8));

      // long arithmetic sweep over occupancy, pointer phase and lookup address
      for (int k = 0; k < 600; k++)
         cyc((k % 3) != 0, AW'((k * 5) % 8), DW'(k * 37 + 1),
             ((k / 7) % 2 == 0) ? ((k % 2) == 0) : ((k % 5) != 0),
             (k % 11) != 0, AW'((k * 3 + k / 8) % 8));

      for (int k = 0; k < 8; k++) cyc(0, '0, '0, 1, 1, AW'(k));
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule